// File: doc/BRIEF.md
# Divider Pair Search Engine

This engine picks the setting for a two-stage integer clock divider: a pre-divider (1 to 8) followed by a post-divider (1 to 64). It takes the parent frequency and the wanted frequency as 32-bit unsigned integers. It then tries every pre/post pair and keeps the pair whose truncated output frequency lies closest to the wanted one. When the search ends, it reports that pair in divide-minus-one form, ready to load into divider fields. It also reports the frequency the pair achieves, with each stage rounded up.

A request is made by pulsing `start` while the engine is idle. The engine latches both operands and raises `busy`. It walks the pairs with one shared iterative divider. At the end it pulses `done` for one cycle with the results on the output registers. The search always takes the same number of cycles, about 5.2k at the default parameters. A parent frequency of zero skips the search.

Top module: `dps_search`

## Requirements
- R1: For a nonzero parent, the result is the pair minimising the error magnitude. Each candidate frequency is (parent / pre) / post, truncated at each stage. The pre-divider runs 1..8 in the outer loop and the post-divider runs 1..64 in the inner loop.
- R2: A candidate replaces the kept pair only when its error magnitude is strictly smaller. On equal errors, the pair met first in loop order is kept (lower pre first, then lower post).
- R3: The search starts from the pair (1,1) with a kept error magnitude of 2^31-1. If no candidate falls strictly below that, the result is the pair (1,1).
- R4: `pre_code` carries pre-1 (3 bits) and `post_code` carries post-1 (6 bits).
- R5: `rate_hz` equals ceil(ceil(parent / pre) / post) for the chosen pair.
- R6: The error is the 33-bit signed difference candidate minus target, compared by magnitude. A target above the parent, or near 2^32-1, therefore does not wrap.
- R7: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted start up to, but not including, the `done` cycle. The outputs change only in a `done` cycle.
- R8: A `start` pulse while `busy` is high is ignored. The running search keeps its operands and its result.
- R9: A parent of zero raises `done` in the cycle after `start`, with both codes 0 and `rate_hz` 0, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| parent_hz | input | 32 | Parent frequency, sampled at start |
| target_hz | input | 32 | Wanted frequency, sampled at start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| pre_code | output | 3 | Chosen pre-divider minus one |
| post_code | output | 6 | Chosen post-divider minus one |
| rate_hz | output | 32 | Achieved frequency, each stage rounded up |

## Verification
The search is driven with several operand patterns, each aimed at one failure:
- An exactly divisible pair checks the field encoding.
- A parent with many equal-error factorings checks that the earliest pair is kept.
- A ratio with a remainder makes the rounded-up rate differ from the truncated one.
- A target above the parent exposes any wrap in the signed difference.
- Extreme operands (all-ones parent with zero target, small parent with all-ones target) show whether the initial error limit is honoured.

A zero parent and a start pulse during a running search cover the short path and the ignore rule.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_POST,
    S_RUP1,
    S_RUP2
  } dps_state_e;

endpackage

// File: rtl/dps_divider.sv
// Iterative restoring divider; STEPS quotient bits per cycle, W divisible by STEPS.
module dps_divider #(
  parameter int W     = 32,
  parameter int DW    = 7,
  parameter int STEPS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [W-1:0]  num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [W-1:0]  quo,
  output logic [DW-1:0] rem
);

  localparam int ROUNDS = W / STEPS;
  localparam int CW     = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);

  logic [W-1:0]  acc_q, acc_nx;
  logic [DW-1:0] rem_q, rem_nx;
  logic [DW-1:0] den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          done_q;

  always_comb begin
    logic [DW:0]   t;
    logic [W-1:0]  a;
    logic [DW-1:0] r;
    r = rem_q;
    a = acc_q;
    t = '0;
    for (int i = 0; i < STEPS; i++) begin
      t = {r, a[W-1]};
      a = {a[W-2:0], 1'b0};
      if (t >= {1'b0, den_q}) begin
        t    = t - {1'b0, den_q};
        a[0] = 1'b1;
      end
      r = t[DW-1:0];
    end
    acc_nx = a;
    rem_nx = r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        acc_q <= num;
        rem_q <= '0;
        den_q <= den;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        acc_q <= acc_nx;
        rem_q <= rem_nx;
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == LAST) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = acc_q;
  assign rem  = rem_q;

endmodule

// File: rtl/dps_judge.sv
// Error magnitude of one candidate and the strict-improvement decision.
module dps_judge #(
  parameter int W = 32
) (
  input  logic [W-1:0] cand,
  input  logic [W-1:0] target,
  input  logic [W:0]   best_mag,
  output logic [W:0]   mag,
  output logic         better
);

  function automatic logic [W:0] gap_mag(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] diff;
    diff = {1'b0, a} - {1'b0, b};
    return diff[W] ? (~diff + 1'b1) : diff;
  endfunction

  assign mag    = gap_mag(cand, target);
  assign better = (mag < best_mag);

endmodule

// File: rtl/dps_search.sv
module dps_search #(
  parameter int W        = 32,
  parameter int PRE_MAX  = 8,
  parameter int POST_MAX = 64,
  parameter int STEPS    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [W-1:0]                  parent_hz,
  input  logic [W-1:0]                  target_hz,
  output logic                          busy,
  output logic                          done,
  output logic [$clog2(PRE_MAX)-1:0]    pre_code,
  output logic [$clog2(POST_MAX)-1:0]   post_code,
  output logic [W-1:0]                  rate_hz
);
  import dps_pkg::*;

  localparam int PW   = $clog2(PRE_MAX);
  localparam int QW   = $clog2(POST_MAX);
  localparam int BIG  = (PRE_MAX > POST_MAX) ? PRE_MAX : POST_MAX;
  localparam int DW   = $clog2(BIG + 1);
  localparam logic [W:0]    MAG_INIT = {2'b00, {(W-1){1'b1}}};
  localparam logic [PW:0]   PRE_LAST = (PW+1)'(PRE_MAX);
  localparam logic [QW:0]   POST_LAST = (QW+1)'(POST_MAX);

  function automatic logic [W-1:0] round_up(input logic [W-1:0] q, input logic [DW-1:0] r);
    return q + W'(r != '0);
  endfunction

  dps_state_e    st_q;
  logic [W-1:0]  par_q, tgt_q, q1_q;
  logic [PW:0]   pre_q;
  logic [QW:0]   post_q;
  logic [W:0]    best_mag_q;
  logic [PW-1:0] best_pre_q;
  logic [QW-1:0] best_post_q;
  logic          go_q;
  logic [W-1:0]  num_q;
  logic [DW-1:0] den_q;
  logic          done_q;
  logic [PW-1:0] pre_code_q;
  logic [QW-1:0] post_code_q;
  logic [W-1:0]  rate_q;

  // named events for the checker
  logic          div_done;
  logic [W-1:0]  div_quo;
  logic [DW-1:0] div_rem;
  logic          cand_valid;
  logic          cand_better;
  logic [W:0]    cand_mag;
  logic          accept;
  logic          take_cand;
  logic [PW-1:0] win_pre;
  logic [QW-1:0] win_post;

  dps_divider #(.W(W), .DW(DW), .STEPS(STEPS)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (go_q),
    .num  (num_q),
    .den  (den_q),
    .done (div_done),
    .quo  (div_quo),
    .rem  (div_rem)
  );

  dps_judge #(.W(W)) u_judge (
    .cand    (div_quo),
    .target  (tgt_q),
    .best_mag(best_mag_q),
    .mag     (cand_mag),
    .better  (cand_better)
  );

  assign accept     = start && (st_q == S_IDLE);
  assign cand_valid = (st_q == S_POST) && div_done;
  assign take_cand  = cand_valid && cand_better;
  assign win_pre    = take_cand ? PW'(pre_q - 1'b1)  : best_pre_q;
  assign win_post   = take_cand ? QW'(post_q - 1'b1) : best_post_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      par_q       <= '0;
      tgt_q       <= '0;
      q1_q        <= '0;
      pre_q       <= '0;
      post_q      <= '0;
      best_mag_q  <= '0;
      best_pre_q  <= '0;
      best_post_q <= '0;
      go_q        <= 1'b0;
      num_q       <= '0;
      den_q       <= '0;
      done_q      <= 1'b0;
      pre_code_q  <= '0;
      post_code_q <= '0;
      rate_q      <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (accept) begin
            if (parent_hz == '0) begin
              pre_code_q  <= '0;
              post_code_q <= '0;
              rate_q      <= '0;
              done_q      <= 1'b1;
            end else begin
              par_q       <= parent_hz;
              tgt_q       <= target_hz;
              pre_q       <= (PW+1)'(1);
              post_q      <= (QW+1)'(1);
              best_mag_q  <= MAG_INIT;
              best_pre_q  <= '0;
              best_post_q <= '0;
              num_q       <= parent_hz;
              den_q       <= DW'(1);
              go_q        <= 1'b1;
              st_q        <= S_PRE;
            end
          end
        end
        S_PRE: begin
          if (div_done) begin
            q1_q  <= div_quo;
            num_q <= div_quo;
            den_q <= DW'(post_q);
            go_q  <= 1'b1;
            st_q  <= S_POST;
          end
        end
        S_POST: begin
          if (div_done) begin
            if (take_cand) begin
              best_mag_q  <= cand_mag;
              best_pre_q  <= win_pre;
              best_post_q <= win_post;
            end
            go_q <= 1'b1;
            if (post_q != POST_LAST) begin
              post_q <= post_q + 1'b1;
              num_q  <= q1_q;
              den_q  <= DW'(post_q) + DW'(1);
            end else if (pre_q != PRE_LAST) begin
              pre_q  <= pre_q + 1'b1;
              post_q <= (QW+1)'(1);
              num_q  <= par_q;
              den_q  <= DW'(pre_q) + DW'(1);
              st_q   <= S_PRE;
            end else begin
              num_q <= par_q;
              den_q <= DW'(win_pre) + DW'(1);
              st_q  <= S_RUP1;
            end
          end
        end
        S_RUP1: begin
          if (div_done) begin
            num_q <= round_up(div_quo, div_rem);
            den_q <= DW'(best_post_q) + DW'(1);
            go_q  <= 1'b1;
            st_q  <= S_RUP2;
          end
        end
        S_RUP2: begin
          if (div_done) begin
            rate_q      <= round_up(div_quo, div_rem);
            pre_code_q  <= best_pre_q;
            post_code_q <= best_post_q;
            done_q      <= 1'b1;
            st_q        <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign pre_code  = pre_code_q;
  assign post_code = post_code_q;
  assign rate_hz   = rate_q;

endmodule

// File: rtl/dps_search_chk.sv
module dps_search_chk #(
  parameter int W  = 32,
  parameter int PW = 3,
  parameter int QW = 6,
  parameter int DW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [W-1:0]  parent_hz,
  input logic          busy,
  input logic          done,
  input logic [PW-1:0] pre_code,
  input logic [QW-1:0] post_code,
  input logic [W-1:0]  rate_hz,
  input logic          div_done,
  input logic [W-1:0]  div_num,
  input logic [DW-1:0] div_den,
  input logic [W-1:0]  div_quo,
  input logic [DW-1:0] div_rem,
  input logic [W:0]    best_mag,
  input logic [W-1:0]  search_parent
);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R7
  busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R7
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pre_code) && $stable(post_code) && $stable(rate_hz)));

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(search_parent)));

  // R9
  zero_parent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && parent_hz == '0) |=>
      (done && pre_code == '0 && post_code == '0 && rate_hz == '0));

  // R1
  div_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> ((64'(div_quo) * 64'(div_den) + 64'(div_rem) == 64'(div_num))
                  && (div_rem < div_den)));

  // R3
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (best_mag <= $past(best_mag)));

endmodule

bind dps_search dps_search_chk #(.W(W), .PW(PW), .QW(QW), .DW(DW)) u_dps_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .parent_hz    (parent_hz),
  .busy         (busy),
  .done         (done),
  .pre_code     (pre_code),
  .post_code    (post_code),
  .rate_hz      (rate_hz),
  .div_done     (div_done),
  .div_num      (num_q),
  .div_den      (den_q),
  .div_quo      (div_quo),
  .div_rem      (div_rem),
  .best_mag     (best_mag_q),
  .search_parent(par_q)
);

// File: tb/test_dps_search.sv
`timescale 1ns/1ps
module test_dps_search;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] parent_hz, target_hz;
  logic        busy, done;
  logic [2:0]  pre_code;
  logic [5:0]  post_code;
  logic [31:0] rate_hz;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dps_search i_dps_search (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .parent_hz(parent_hz),
    .target_hz(target_hz),
    .busy     (busy),
    .done     (done),
    .pre_code (pre_code),
    .post_code(post_code),
    .rate_hz  (rate_hz)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected result written from the requirements.
  task automatic expect_pick(input longint unsigned p, input longint unsigned t,
                             output longint unsigned pc, output longint unsigned qc,
                             output longint unsigned r);
    longint lim;
    longint e;
    longint unsigned pre, post;
    pre = 1; post = 1; lim = 64'h7FFF_FFFF;
    if (p == 0) begin
      pc = 0; qc = 0; r = 0;
      return;
    end
    for (int a = 1; a <= 8; a++) begin
      for (int b = 1; b <= 64; b++) begin
        e = longint'((p / longint'(a)) / longint'(b)) - longint'(t);
        if (e < 0) e = -e;
        if (e < lim) begin
          lim = e; pre = longint'(a); post = longint'(b);
        end
      end
    end
    pc = pre - 1;
    qc = post - 1;
    r  = (((p + pre - 1) / pre) + post - 1) / post;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 0;
    while (!done && cycles < 20000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic run_case(input longint unsigned p, input longint unsigned t, input string req);
    longint unsigned pc, qc, r;
    int cyc;
    expect_pick(p, t, pc, qc, r);
    @(negedge clk);
    parent_hz = 32'(p); target_hz = 32'(t); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", "busy after start", longint'(busy), 1);
    wait_done(cyc);
    check(done == 1'b1, req, "done seen", longint'(done), 1);
    check(longint'(pre_code) == pc, req, "pre_code", longint'(pre_code), pc);
    check(longint'(post_code) == qc, req, "post_code", longint'(post_code), qc);
    check(longint'(rate_hz) == r, "R5", "rate_hz", longint'(rate_hz), r);
    check(busy == 1'b0, "R7", "busy in done cycle", longint'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R7", "done width", longint'(done), 0);
    check(longint'(rate_hz) == r, "R7", "rate held", longint'(rate_hz), r);
  endtask

  task automatic test_reset;
    rst_n = 1'b0; start = 1'b0; parent_hz = '0; target_hz = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R7", "reset flags", longint'({busy, done}), 0);
    check(pre_code == '0 && post_code == '0, "R4", "reset codes",
          longint'({pre_code, post_code}), 0);
    check(rate_hz == '0, "R5", "reset rate", longint'(rate_hz), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_zero_parent;
    @(negedge clk);
    parent_hz = '0; target_hz = 32'd1234; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R9", "done next cycle", longint'(done), 1);
    check(busy == 1'b0, "R9", "busy low", longint'(busy), 0);
    check(pre_code == '0 && post_code == '0, "R9", "codes zero",
          longint'({pre_code, post_code}), 0);
    check(rate_hz == '0, "R9", "rate zero", longint'(rate_hz), 0);
    @(negedge clk);
  endtask

  task automatic test_ignore_start;
    longint unsigned pc, qc, r;
    int cyc;
    expect_pick(64'd24000000, 64'd27000, pc, qc, r);
    @(negedge clk);
    parent_hz = 32'd24000000; target_hz = 32'd27000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    parent_hz = 32'd999; target_hz = 32'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    parent_hz = '0;
    wait_done(cyc);
    check(longint'(pre_code) == pc, "R8", "pre_code", longint'(pre_code), pc);
    check(longint'(post_code) == qc, "R8", "post_code", longint'(post_code), qc);
    check(longint'(rate_hz) == r, "R8", "rate_hz", longint'(rate_hz), r);
    @(negedge clk);
  endtask

  initial begin
    test_reset();
    run_case(64'd800000000, 64'd100000000, "R4");
    run_case(64'd1000, 64'd333, "R1");
    run_case(64'd600, 64'd100, "R2");
    run_case(64'd1000, 64'd5000, "R6");
    run_case(64'hFFFF_FFFF, 64'd0, "R3");
    run_case(64'd5, 64'hFFFF_FFFF, "R3");
    run_case(64'd24000000, 64'd27000, "R1");
    test_zero_parent();
    test_ignore_start();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule